// File: doc/BRIEF.md
# Microstore Diagnostic Access Port

This block lets a host probe and patch a wide microcode store one 12-bit slice at a time. The host selects a 3-bit diagnostic function, drives a 12-bit transfer buffer and pulses single-cycle strobes. A receive strobe captures the buffer into a transceiver register. A write strobe stores that register into the slice chosen by the function at the current store address. A step strobe copies the addressed microword into the output latches. A clear strobe zeroes the latches. A transmit strobe captures the value chosen by the function into the readback register.

Function codes 1 and 2 choose different things for a write than for a read. Code 1 writes the middle slice, but as a read it returns the next store address. Code 2 writes both copies of the top slice, but as a read it returns the transceiver contents, which lets the host check that bus data loops back. A parity flag watches the low 36 latched bits.

Top module: `ucode_diag_port`

## Requirements
- R1: After reset, rd_data_o, uword_o and par_err_o are all zero.
- R2: A rx_stb_i pulse loads buf_i into the transceiver register. A transmit with function 2 returns that register.
- R3: A wr_stb_i pulse stores the transceiver register at addr_i. Function 0 writes uword bits [11:0]. Function 1 writes [23:12]. Function 2 writes both [35:24] (copy A) and [47:36] (copy B). Functions 3 to 7 write nothing.
- R4: A step_stb_i pulse loads the word at addr_i into uword_o one cycle later. The same pulse loads addr_i into the current-location register.
- R5: A transmit with function 0, 4, 5 or 6 returns latched bits [11:0], [23:12], [35:24] or [47:36] respectively.
- R6: A transmit with function 1 returns addr_i, zero-extended. A transmit with function 3 returns the current-location register.
- R7: A transmit with function 7 returns zero.
- R8: A clr_stb_i pulse forces every latch bit to zero. The clear wins over a step pulse in the same cycle, although that step still updates the current location.
- R9: par_err_o is high exactly when uword_o[35:0] holds an odd number of ones.
- R10: rd_data_o changes only in the cycle after a tx_stb_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fn_i | input | 3 | Diagnostic function code |
| buf_i | input | SLICE_W | Host transfer buffer |
| rx_stb_i | input | 1 | Capture buf_i into the transceiver register |
| wr_stb_i | input | 1 | Write the slice chosen by fn_i at addr_i |
| step_stb_i | input | 1 | Load the addressed word into the latches |
| clr_stb_i | input | 1 | Zero the output latches |
| tx_stb_i | input | 1 | Capture the selected readback value |
| addr_i | input | ADDR_W | Current or next store address |
| rd_data_o | output | SLICE_W | Readback register |
| uword_o | output | 4*SLICE_W | Output latches |
| par_err_o | output | 1 | Parity error on latched bits [35:0] |

## Verification
A wrong decode or a bad store cell shows only after a step. The next transmit then returns a slice that differs from what the bench model wrote. So a fault surfaces two strobes after the write that caused it. A latch that a clear does not reach, or a missing parity term, shows in uword_o or par_err_o one cycle after the strobe. The bench compares every output after every strobe against a reference model of the store, the latches and the readback register.

// File: rtl/mdiag_pkg.sv
package mdiag_pkg;
  localparam int FN_W   = 3;
  localparam int NSLICE = 4;

  typedef enum logic [FN_W-1:0] {
    FN_LOW    = 3'd0,
    FN_MID    = 3'd1,
    FN_HI     = 3'd2,
    FN_CUR    = 3'd3,
    FN_RD_MID = 3'd4,
    FN_RD_HIA = 3'd5,
    FN_RD_HIB = 3'd6,
    FN_ZERO   = 3'd7
  } diag_fn_e;
endpackage

// File: rtl/mdiag_decode.sv
module mdiag_decode
  import mdiag_pkg::*;
(
  input  logic [FN_W-1:0]   fn_i,
  input  logic              wr_stb_i,
  output logic [NSLICE-1:0] we_o
);
  always_comb begin
    we_o = '0;
    if (wr_stb_i) begin
      unique case (diag_fn_e'(fn_i))
        FN_LOW:  we_o = 4'b0001;
        FN_MID:  we_o = 4'b0010;
        FN_HI:   we_o = 4'b1100;  // both copies of the top slice
        default: we_o = '0;
      endcase
    end
  end

  always_comb begin
    assert ($countones(we_o) <= 2)
      else $error("a_r3_we_count");
  end
endmodule

// File: rtl/mdiag_store.sv
module mdiag_store
  import mdiag_pkg::*;
#(
  parameter int SLICE_W = 12,
  parameter int ADDR_W  = 10,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                        clk_i,
  input  logic [NSLICE-1:0]           we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [SLICE_W-1:0]          wdata_i,
  output logic [NSLICE*SLICE_W-1:0]   rword_o
);
  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [SLICE_W-1:0] arr [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[s]) arr[addr_i] <= wdata_i;
    end
    assign rword_o[s*SLICE_W +: SLICE_W] = arr[addr_i];
  end
endmodule

// File: rtl/mdiag_latch.sv
module mdiag_latch
  import mdiag_pkg::*;
#(
  parameter int SLICE_W = 12,
  parameter int ADDR_W  = 10,
  localparam int WORD_W = NSLICE * SLICE_W,
  localparam int PAR_W  = 3 * SLICE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] rword_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] lat_o,
  output logic [ADDR_W-1:0] cur_o,
  output logic              par_err_o
);
  logic [WORD_W-1:0] lat_q;
  logic [ADDR_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      cur_q <= '0;
    end else begin
      if (clr_i)       lat_q <= '0;
      else if (step_i) lat_q <= rword_i;
      if (step_i)      cur_q <= addr_i;
    end
  end

  assign lat_o     = lat_q;
  assign cur_o     = cur_q;
  assign par_err_o = ^lat_q[PAR_W-1:0];

  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> lat_o == '0);
  a_r9_clear_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !par_err_o);
  a_r4_cur_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> cur_o == $past(addr_i));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !clr_i |=> $stable(lat_o));
endmodule

// File: rtl/mdiag_readback.sv
module mdiag_readback
  import mdiag_pkg::*;
#(
  parameter int SLICE_W = 12,
  parameter int ADDR_W  = 10,
  localparam int WORD_W = NSLICE * SLICE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FN_W-1:0]    fn_i,
  input  logic [SLICE_W-1:0] buf_i,
  input  logic               rx_i,
  input  logic               tx_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ADDR_W-1:0]  cur_i,
  input  logic [WORD_W-1:0]  lat_i,
  output logic [SLICE_W-1:0] xcvr_o,
  output logic [SLICE_W-1:0] rd_o
);
  logic [SLICE_W-1:0] xcvr_q, rd_q, sel, nxt_ext, cur_ext;

  always_comb begin
    nxt_ext = '0;
    nxt_ext[ADDR_W-1:0] = addr_i;
    cur_ext = '0;
    cur_ext[ADDR_W-1:0] = cur_i;
  end

  always_comb begin
    unique case (diag_fn_e'(fn_i))
      FN_LOW:    sel = lat_i[0*SLICE_W +: SLICE_W];
      FN_MID:    sel = nxt_ext;
      FN_HI:     sel = xcvr_q;
      FN_CUR:    sel = cur_ext;
      FN_RD_MID: sel = lat_i[1*SLICE_W +: SLICE_W];
      FN_RD_HIA: sel = lat_i[2*SLICE_W +: SLICE_W];
      FN_RD_HIB: sel = lat_i[3*SLICE_W +: SLICE_W];
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xcvr_q <= '0;
      rd_q   <= '0;
    end else begin
      if (rx_i) xcvr_q <= buf_i;
      if (tx_i) rd_q   <= sel;
    end
  end

  assign xcvr_o = xcvr_q;
  assign rd_o   = rd_q;

  a_r7_fn7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_i && fn_i == 3'd7 |=> rd_o == '0);
  a_r10_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_i |=> $stable(rd_o));
  a_r2_loopback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_i |=> xcvr_o == $past(buf_i));
endmodule

// File: rtl/ucode_diag_port.sv
module ucode_diag_port
  import mdiag_pkg::*;
#(
  parameter int SLICE_W = 12,
  parameter int ADDR_W  = 10,
  localparam int WORD_W = NSLICE * SLICE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         fn_i,
  input  logic [SLICE_W-1:0] buf_i,
  input  logic               rx_stb_i,
  input  logic               wr_stb_i,
  input  logic               step_stb_i,
  input  logic               clr_stb_i,
  input  logic               tx_stb_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [SLICE_W-1:0] rd_data_o,
  output logic [WORD_W-1:0]  uword_o,
  output logic               par_err_o
);
  logic [NSLICE-1:0]  we;
  logic [SLICE_W-1:0] xcvr;
  logic [WORD_W-1:0]  rword;
  logic [ADDR_W-1:0]  cur;

  mdiag_decode i_decode (
    .fn_i     (fn_i),
    .wr_stb_i (wr_stb_i),
    .we_o     (we)
  );

  mdiag_store #(.SLICE_W(SLICE_W), .ADDR_W(ADDR_W)) i_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .addr_i  (addr_i),
    .wdata_i (xcvr),
    .rword_o (rword)
  );

  mdiag_latch #(.SLICE_W(SLICE_W), .ADDR_W(ADDR_W)) i_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_stb_i),
    .clr_i     (clr_stb_i),
    .rword_i   (rword),
    .addr_i    (addr_i),
    .lat_o     (uword_o),
    .cur_o     (cur),
    .par_err_o (par_err_o)
  );

  mdiag_readback #(.SLICE_W(SLICE_W), .ADDR_W(ADDR_W)) i_readback (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fn_i   (fn_i),
    .buf_i  (buf_i),
    .rx_i   (rx_stb_i),
    .tx_i   (tx_stb_i),
    .addr_i (addr_i),
    .cur_i  (cur),
    .lat_i  (uword_o),
    .xcvr_o (xcvr),
    .rd_o   (rd_data_o)
  );

  initial begin
    assert (ADDR_W <= SLICE_W) else $error("a_r6_addr_fits");
  end

  a_r3_step_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i && fn_i == 3'd0 ##1 step_stb_i && !clr_stb_i && $stable(addr_i)
    |=> uword_o[SLICE_W-1:0] == $past(xcvr, 2));
endmodule

// File: tb/test_ucode_diag_port.sv
`timescale 1ns/1ps
module test_ucode_diag_port;
  localparam int SW = 12;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] fn = '0;
  logic [SW-1:0] bufv = '0;
  logic rx = 0, wr = 0, step = 0, clr = 0, tx = 0;
  logic [AW-1:0] addr = '0;
  logic [SW-1:0] rd;
  logic [4*SW-1:0] uw;
  logic perr;

  always #2 clk = ~clk;

  ucode_diag_port #(.SLICE_W(SW), .ADDR_W(AW)) i_ucode_diag_port (
    .clk_i(clk), .rst_ni(rst_n), .fn_i(fn), .buf_i(bufv),
    .rx_stb_i(rx), .wr_stb_i(wr), .step_stb_i(step), .clr_stb_i(clr),
    .tx_stb_i(tx), .addr_i(addr), .rd_data_o(rd), .uword_o(uw),
    .par_err_o(perr)
  );

  int checks = 0;
  int fails = 0;

  logic [SW-1:0] m_mem [4][DEPTH];
  logic [SW-1:0] m_x = '0;
  logic [4*SW-1:0] m_lat = '0;
  logic [AW-1:0] m_cur = '0;
  logic [SW-1:0] m_rd = '0;

  task automatic chk(string req, logic [4*SW-1:0] act, logic [4*SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] exp_rd(logic [2:0] f, logic [AW-1:0] a);
    logic [SW-1:0] z;
    z = '0;
    case (f)
      3'd0: return m_lat[0*SW +: SW];
      3'd1: begin z[AW-1:0] = a; return z; end
      3'd2: return m_x;
      3'd3: begin z[AW-1:0] = m_cur; return z; end
      3'd4: return m_lat[1*SW +: SW];
      3'd5: return m_lat[2*SW +: SW];
      3'd6: return m_lat[3*SW +: SW];
      default: return '0;
    endcase
  endfunction

  // op: 0 rx, 1 wr, 2 step, 3 clr, 4 tx, 5 step+clr
  task automatic op(int kind, logic [2:0] f, logic [AW-1:0] a, logic [SW-1:0] d, string req);
    @(negedge clk);
    fn = f; addr = a; bufv = d;
    rx = (kind == 0); wr = (kind == 1); step = (kind == 2 || kind == 5);
    clr = (kind == 3 || kind == 5); tx = (kind == 4);
    case (kind)
      0: m_x = d;
      1: case (f)
           3'd0: m_mem[0][a] = m_x;
           3'd1: m_mem[1][a] = m_x;
           3'd2: begin m_mem[2][a] = m_x; m_mem[3][a] = m_x; end
           default: ;
         endcase
      2: begin
           m_lat = {m_mem[3][a], m_mem[2][a], m_mem[1][a], m_mem[0][a]};
           m_cur = a;
         end
      3: m_lat = '0;
      4: m_rd = exp_rd(f, a);
      5: begin m_lat = '0; m_cur = a; end
      default: ;
    endcase
    @(negedge clk);
    rx = 0; wr = 0; step = 0; clr = 0; tx = 0;
    chk({req, " rd"}, {36'd0, rd}, {36'd0, m_rd});
    chk({req, " latch"}, uw, m_lat);
    chk("R9 parity", {47'd0, perr}, {47'd0, ^m_lat[3*SW-1:0]});
  endtask

  task automatic put(logic [2:0] f, logic [AW-1:0] a, logic [SW-1:0] d, string req);
    op(0, f, a, d, "R2");
    op(1, f, a, d, req);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 rd", {36'd0, rd}, '0);
    chk("R1 latch", uw, '0);
    chk("R1 parity", {47'd0, perr}, '0);
    rst_n = 1'b1;

    // preload addresses 0..31
    for (int a = 0; a < 32; a++) begin
      put(3'd0, AW'(a), SW'($urandom), "R3");
      put(3'd1, AW'(a), SW'($urandom), "R3");
      put(3'd2, AW'(a), SW'($urandom), "R3");
    end

    // R2 loopback
    op(0, 3'd2, '0, 12'hA5C, "R2");
    op(4, 3'd2, '0, '0, "R2");
    chk("R2 loopback", {36'd0, rd}, {36'd0, 12'hA5C});

    // R3 functions 3..7 write nothing
    for (int f = 3; f < 8; f++) put(3'(f), 10'd5, 12'hFFF ^ SW'(f), "R3");
    op(2, 3'd0, 10'd5, '0, "R4");
    op(4, 3'd0, 10'd5, '0, "R5");
    op(4, 3'd4, 10'd5, '0, "R5");
    op(4, 3'd5, 10'd5, '0, "R5");
    op(4, 3'd6, 10'd5, '0, "R5");

    // R6 next address and current location
    op(4, 3'd1, 10'h3FF, '0, "R6");
    chk("R6 next", {36'd0, rd}, {36'd0, 12'h3FF});
    op(4, 3'd3, 10'h000, '0, "R6");
    chk("R6 cur", {36'd0, rd}, 48'd5);

    // R7 zero
    op(4, 3'd7, 10'h3FF, '0, "R7");
    chk("R7 zero", {36'd0, rd}, '0);

    // R9 parity odd then even
    put(3'd0, 10'd40, 12'h001, "R3");
    put(3'd1, 10'd40, 12'h000, "R3");
    put(3'd2, 10'd40, 12'h000, "R3");
    op(2, 3'd0, 10'd40, '0, "R4");
    chk("R9 odd", {47'd0, perr}, 48'd1);
    put(3'd2, 10'd40, 12'h800, "R3");
    op(2, 3'd0, 10'd40, '0, "R4");
    chk("R9 even", {47'd0, perr}, '0);

    // R8 clear beats step
    op(2, 3'd0, 10'd7, '0, "R4");
    op(5, 3'd0, 10'd9, '0, "R8");
    chk("R8 clear", uw, '0);
    op(4, 3'd3, 10'd0, '0, "R8");
    chk("R8 cur", {36'd0, rd}, 48'd9);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 5);
      op(k, 3'($urandom_range(0, 7)), AW'($urandom_range(0, 31)),
         SW'($urandom), "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule